// File: doc/BRIEF.md
# Endpoint Ping-Pong Buffer Pointer Manager

This block holds the descriptors of a small ring of packet buffers (two by default) that serve one endpoint from a shared on-chip packet memory. Each descriptor carries three fields: a word pointer into that memory, a byte count and an ownership flag. The processor writes a descriptor and clears its ownership flag to hand the buffer to the core. The protocol layer always sees the descriptor that is current. When that descriptor is not handed over, the block reports "not ready" and the protocol layer answers NAK.

When a transaction on the current buffer completes, the block takes the buffer back for the processor by setting its ownership flag. For a receive (OUT) endpoint it also replaces the byte count with the number of bytes that actually arrived. It then raises that buffer's done flag and moves on to the next buffer. Software can therefore refill one buffer while the core works on the other. Each done flag is held until the processor clears it by writing a one, and the interrupt output is asserted while any done flag is set.

Top module: `epbuf_pingpong`

## Requirements
- R1: After reset the current index is 0, every ownership flag reads 1 (processor-owned), no done flag is set, `irq` is 0 and `nxt_rdy` is 0.
- R2: A cycle with `cfg_we` high loads pointer, byte count and ownership flag of buffer `cfg_sel`; the new values read back on `rd_*` from the next cycle.
- R3: `nxt_rdy` is 1 exactly when the current buffer's ownership flag is 0, and `nxt_ptr`/`nxt_size` show the current buffer's pointer and byte count.
- R4: `xfer_done` while `nxt_rdy` is 1 completes the current buffer: from the next cycle its ownership flag is 1 and `nxt_idx` has advanced (0,1,...,NBUF-1,0).
- R5: `xfer_done` while `nxt_rdy` is 0 is ignored: index, done flags and descriptors are unchanged.
- R6: On completion with `ep_out`=1 (OUT) the buffer's byte count becomes `xfer_cnt`; with `ep_out`=0 (IN) it is left unchanged.
- R7: An OUT completion whose `xfer_cnt` exceeds the buffer's byte count stores the byte count unchanged (saturation).
- R8: Completion sets done flag `irq_pend[i]` of buffer i. `irq` is high while any done flag is set. A 1 on `irq_ack[i]` clears that flag, except in a cycle where the same flag is being set, in which case it stays set.
- R9: When a processor write and a completion address the same buffer in one cycle, the completion wins and the whole write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | IDX_W | Buffer written |
| cfg_ptr | input | PTR_W | Word pointer to load |
| cfg_size | input | SIZE_W | Byte count to load |
| cfg_used | input | 1 | Ownership flag to load (0 = core may use) |
| rd_sel | input | IDX_W | Buffer read back |
| rd_ptr | output | PTR_W | Pointer of buffer rd_sel |
| rd_size | output | SIZE_W | Byte count of buffer rd_sel |
| rd_used | output | 1 | Ownership flag of buffer rd_sel |
| irq_ack | input | NBUF | Write-one-to-clear of done flags |
| irq_pend | output | NBUF | Done flags per buffer |
| irq | output | 1 | OR of done flags |
| ep_out | input | 1 | Direction: 1 = OUT (receive), 0 = IN |
| xfer_done | input | 1 | Protocol layer finished the current buffer |
| xfer_cnt | input | SIZE_W | Bytes received (OUT) |
| nxt_rdy | output | 1 | Current buffer is handed to the core |
| nxt_idx | output | IDX_W | Current buffer index |
| nxt_ptr | output | PTR_W | Current buffer pointer |
| nxt_size | output | SIZE_W | Current buffer byte count |

## Verification
The bench builds the block with its defaults: two buffers, a 512-word memory (9-bit pointers, 12-bit byte counts) and count saturation enabled. With two buffers the index wraps after every second completion. This brings the wrap, the NAK case in which the next buffer is still processor-owned, and a late refill within a few transactions. With saturation enabled, an oversized OUT count shows whether the stored byte count is limited to the space that was offered.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
   typedef enum logic {
      DIR_IN  = 1'b0,
      DIR_OUT = 1'b1
   } ep_dir_e;

   localparam int DEF_MEM_WORDS = 512;
   localparam int DEF_NBUF      = 2;
endpackage

// File: rtl/epbuf_slot.sv
module epbuf_slot #(
   parameter int PTR_W     = 9,
   parameter int SIZE_W    = 12,
   parameter bit CLAMP_CNT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [SIZE_W-1:0] wr_size,
   input  logic              wr_used,
   input  logic              fin,
   input  logic              fin_out,
   input  logic [SIZE_W-1:0] fin_cnt,
   output logic [PTR_W-1:0]  ptr,
   output logic [SIZE_W-1:0] size,
   output logic              used
);
   logic [SIZE_W-1:0] wb_cnt;

   generate
      if (CLAMP_CNT) begin : g_clamp
         assign wb_cnt = (fin_cnt > size) ? size : fin_cnt;
      end else begin : g_raw
         assign wb_cnt = fin_cnt;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr  <= '0;
         size <= '0;
         used <= 1'b1;
      end else if (fin) begin
         used <= 1'b1;
         if (fin_out) size <= wb_cnt;
      end else if (wr_en) begin
         ptr  <= wr_ptr;
         size <= wr_size;
         used <= wr_used;
      end
   end
endmodule

// File: rtl/epbuf_sel.sv
module epbuf_sel #(
   parameter int NBUF  = 2,
   parameter int IDX_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] cur
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NBUF - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur <= '0;
      else if (adv)
         cur <= (cur == LAST) ? '0 : cur + 1'b1;
   end
endmodule

// File: rtl/epbuf_irq.sv
module epbuf_irq #(
   parameter int NBUF = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NBUF-1:0] set,
   input  logic [NBUF-1:0] ack,
   output logic [NBUF-1:0] pend,
   output logic            irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~ack) | set;
   end

   assign irq = |pend;
endmodule

// File: rtl/epbuf_pingpong.sv
module epbuf_pingpong #(
   parameter int MEM_WORDS = epbuf_pkg::DEF_MEM_WORDS,
   parameter int NBUF      = epbuf_pkg::DEF_NBUF,
   parameter bit CLAMP_CNT = 1'b1,
   localparam int PTR_W    = $clog2(MEM_WORDS),
   localparam int SIZE_W   = $clog2(MEM_WORDS * 4) + 1,
   localparam int IDX_W    = (NBUF > 1) ? $clog2(NBUF) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_sel,
   input  logic [PTR_W-1:0]  cfg_ptr,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic              cfg_used,
   input  logic [IDX_W-1:0]  rd_sel,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic [SIZE_W-1:0] rd_size,
   output logic              rd_used,
   input  logic [NBUF-1:0]   irq_ack,
   output logic [NBUF-1:0]   irq_pend,
   output logic              irq,
   input  logic              ep_out,
   input  logic              xfer_done,
   input  logic [SIZE_W-1:0] xfer_cnt,
   output logic              nxt_rdy,
   output logic [IDX_W-1:0]  nxt_idx,
   output logic [PTR_W-1:0]  nxt_ptr,
   output logic [SIZE_W-1:0] nxt_size
);
   import epbuf_pkg::*;

   if (NBUF < 2) begin : g_chk_nbuf
      $error("epbuf_pingpong: NBUF must be at least 2");
   end
   if ((1 << PTR_W) != MEM_WORDS) begin : g_chk_mem
      $error("epbuf_pingpong: MEM_WORDS must be a power of two");
   end

   logic [PTR_W-1:0]  s_ptr  [NBUF];
   logic [SIZE_W-1:0] s_size [NBUF];
   logic [NBUF-1:0]   s_used;
   logic [NBUF-1:0]   fin_vec;
   logic              fire;
   logic              is_out;

   assign is_out = (ep_dir_e'(ep_out) == DIR_OUT);

   epbuf_sel #(.NBUF(NBUF), .IDX_W(IDX_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .adv(fire), .cur(nxt_idx)
   );

   assign nxt_rdy  = ~s_used[nxt_idx];
   assign nxt_ptr  = s_ptr[nxt_idx];
   assign nxt_size = s_size[nxt_idx];
   assign fire     = xfer_done & nxt_rdy;

   for (genvar i = 0; i < NBUF; i++) begin : g_slot
      assign fin_vec[i] = fire && (nxt_idx == IDX_W'(i));

      epbuf_slot #(.PTR_W(PTR_W), .SIZE_W(SIZE_W), .CLAMP_CNT(CLAMP_CNT)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .wr_en(cfg_we && (cfg_sel == IDX_W'(i))),
         .wr_ptr(cfg_ptr), .wr_size(cfg_size), .wr_used(cfg_used),
         .fin(fin_vec[i]), .fin_out(is_out), .fin_cnt(xfer_cnt),
         .ptr(s_ptr[i]), .size(s_size[i]), .used(s_used[i])
      );
   end

   assign rd_ptr  = s_ptr[rd_sel];
   assign rd_size = s_size[rd_sel];
   assign rd_used = s_used[rd_sel];

   epbuf_irq #(.NBUF(NBUF)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(fin_vec), .ack(irq_ack),
      .pend(irq_pend), .irq(irq)
   );
endmodule

// File: rtl/epbuf_chk.sv
module epbuf_chk #(
   parameter int NBUF  = 2,
   parameter int IDX_W = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic             xfer_done,
   input logic             nxt_rdy,
   input logic [IDX_W-1:0] nxt_idx,
   input logic [NBUF-1:0]  irq_pend,
   input logic             irq
);
   // R4: a completion moves to another buffer
   a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && nxt_rdy) |=> (nxt_idx != $past(nxt_idx)));

   // R5: without an accepted completion the index holds
   a_r5_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(xfer_done && nxt_rdy) |=> $stable(nxt_idx));

   // R3: a processor-owned current buffer stays unavailable until software writes
   a_r3_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!nxt_rdy && !cfg_we) |=> !nxt_rdy);

   // R8: a completion raises the interrupt
   a_r8_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && nxt_rdy) |=> (irq && (irq_pend != '0)));

   // R8: done flags never multiply without a completion
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(xfer_done && nxt_rdy) |=> ($countones(irq_pend) <= $countones($past(irq_pend))));
endmodule

bind epbuf_pingpong epbuf_chk #(.NBUF(NBUF), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .xfer_done(xfer_done),
   .nxt_rdy(nxt_rdy), .nxt_idx(nxt_idx), .irq_pend(irq_pend), .irq(irq)
);

// File: tb/sim_epbuf_pingpong.sv
`timescale 1ns/1ps
module sim_epbuf_pingpong;
   localparam int PW = 9;
   localparam int SW = 12;
   localparam int IW = 1;
   localparam int NB = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_sel = '0;
   logic [PW-1:0] cfg_ptr = '0;
   logic [SW-1:0] cfg_size = '0;
   logic          cfg_used = 1'b0;
   logic [IW-1:0] rd_sel = '0;
   logic [PW-1:0] rd_ptr;
   logic [SW-1:0] rd_size;
   logic          rd_used;
   logic [NB-1:0] irq_ack = '0;
   logic [NB-1:0] irq_pend;
   logic          irq;
   logic          ep_out = 1'b0;
   logic          xfer_done = 1'b0;
   logic [SW-1:0] xfer_cnt = '0;
   logic          nxt_rdy;
   logic [IW-1:0] nxt_idx;
   logic [PW-1:0] nxt_ptr;
   logic [SW-1:0] nxt_size;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   epbuf_pingpong u0 (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_slot(input string tag, input int idx, input int p, input int s, input bit u);
      rd_sel = IW'(idx);
      #1;
      chk({tag, " ptr"},  32'(rd_ptr),  32'(p));
      chk({tag, " size"}, 32'(rd_size), 32'(s));
      chk({tag, " used"}, 32'(rd_used), 32'(u));
   endtask

   task automatic cfg_write(input int idx, input int p, input int s, input bit u);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = IW'(idx); cfg_ptr = PW'(p); cfg_size = SW'(s); cfg_used = u;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic complete(input bit out, input int cnt);
      @(negedge clk);
      xfer_done = 1'b1; ep_out = out; xfer_cnt = SW'(cnt);
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   task automatic ack(input logic [NB-1:0] m);
      @(negedge clk);
      irq_ack = m;
      @(negedge clk);
      irq_ack = '0;
   endtask

   task automatic t_reset;
      chk("R1 idx", 32'(nxt_idx), 0);
      chk("R1 rdy", 32'(nxt_rdy), 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 pend", 32'(irq_pend), 0);
      chk_slot("R1 buf0", 0, 0, 0, 1'b1);
      chk_slot("R1 buf1", 1, 0, 0, 1'b1);
   endtask

   task automatic t_nak;
      complete(1'b0, 0);
      chk("R5 nak idx", 32'(nxt_idx), 0);
      chk("R5 nak pend", 32'(irq_pend), 0);
      chk("R5 nak irq", 32'(irq), 0);
   endtask

   task automatic t_cfg;
      cfg_write(0, 'h040, 64, 1'b0);
      chk_slot("R2 buf0", 0, 'h040, 64, 1'b0);
      chk("R3 rdy", 32'(nxt_rdy), 1);
      chk("R3 ptr", 32'(nxt_ptr), 'h040);
      chk("R3 size", 32'(nxt_size), 64);
      cfg_write(1, 'h100, 32, 1'b0);
      chk_slot("R2 buf1", 1, 'h100, 32, 1'b0);
   endtask

   task automatic t_in;
      complete(1'b0, 5);
      chk("R4 idx after first", 32'(nxt_idx), 1);
      chk("R8 pend buf0", 32'(irq_pend), 'b01);
      chk("R8 irq", 32'(irq), 1);
      chk_slot("R6 IN buf0 kept", 0, 'h040, 64, 1'b1);
      chk("R3 ptr buf1", 32'(nxt_ptr), 'h100);
      ack(2'b01);
      chk("R8 ack clears", 32'(irq_pend), 0);
      chk("R8 irq low", 32'(irq), 0);
      complete(1'b0, 7);
      chk("R4 wrap idx", 32'(nxt_idx), 0);
      chk("R8 pend buf1", 32'(irq_pend), 'b10);
      chk("R3 not ready", 32'(nxt_rdy), 0);
      complete(1'b0, 3);
      chk("R5 ignored idx", 32'(nxt_idx), 0);
      chk("R5 ignored pend", 32'(irq_pend), 'b10);
      ack(2'b10);
   endtask

   task automatic t_out;
      cfg_write(0, 'h080, 100, 1'b0);
      complete(1'b1, 40);
      chk_slot("R6 OUT buf0", 0, 'h080, 40, 1'b1);
      chk("R4 idx", 32'(nxt_idx), 1);
      cfg_write(1, 'h120, 20, 1'b0);
      complete(1'b1, 50);
      chk_slot("R7 OUT clamp buf1", 1, 'h120, 20, 1'b1);
      chk("R4 idx wrap", 32'(nxt_idx), 0);
      chk("R8 pend both", 32'(irq_pend), 'b11);
   endtask

   task automatic t_race;
      cfg_write(0, 'h080, 8, 1'b0);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = '0; cfg_ptr = 'h1FF; cfg_size = 99; cfg_used = 1'b0;
      xfer_done = 1'b1; ep_out = 1'b0; xfer_cnt = '0;
      irq_ack = 2'b01;
      @(negedge clk);
      cfg_we = 1'b0; xfer_done = 1'b0; irq_ack = '0;
      chk("R8 set beats ack", 32'(irq_pend), 'b11);
      chk_slot("R9 write dropped", 0, 'h080, 8, 1'b1);
      chk("R4 idx", 32'(nxt_idx), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_nak();
      t_cfg();
      t_in();
      t_out();
      t_race();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule